// File: doc/BRIEF.md
# Looping Instruction Pump with Hatch

The pump is the instruction-side front end of a programmable port. Instruction words arrive on a valid/ready input and first collect in an epilogue queue. A two-state gate, the hatch, stands between that queue and a circular instruction queue. From the instruction queue, words move one at a time to a single on-deck stage. The on-deck stage presents the word to external execute logic and waits for that logic to report completion. The meaning of each instruction is decoded outside the pump. The pump reads only three flag bits at the top of the word.

An on-deck word that is not marked single-use is copied back into the instruction queue while the outer loop count is nonzero. The copy is made only after the hatch has closed. In this way a group of instructions ended by a tail marker repeats as an outer loop. Words that follow the tail wait in the epilogue queue until the outer count reaches zero. A separate torpedo input parks one interrupt token. If an interruptible on-deck word passes its predicate while a token is parked, the word is killed instead of executed, the token is consumed, the hatch reopens and an acknowledgment pulse is sent.

Top module: `instr_pump`

## Requirements
- R1: After reset, in_ready_o and torp_ready_o are 1, od_valid_o, od_kill_o and tack_o are 0, and the hatch is open.
- R2: With the hatch open, an instruction accepted on a clock edge is on deck (od_valid_o = 1) after the second following edge. Instructions reach the deck in arrival order.
- R3: A word with bit IW-1 set (tail) closes the hatch when it leaves the epilogue queue and never appears on deck. While the hatch is closed, later words stay in the epilogue queue.
- R4: A 0-to-1 transition of olc_zero_i reopens the hatch, and the held words then proceed to the deck.
- R5: The next word comes on deck only after exec_done_i (or a kill) has retired the current one and its recirculation decision has completed. od_valid_o is low for at least one cycle after a retirement.
- R6: An on-deck word with bit IW-2 (one-shot) clear is copied back into the instruction queue once the hatch is closed, provided olc_zero_i is 0 and the word was not killed. The copy comes on deck again.
- R7: A one-shot word, or any word while olc_zero_i is 1, is not copied back.
- R8: If the on-deck word has bit IW-3 (interruptible) set, pred_ok_i is 1 and a torpedo is held, then od_kill_o is 1 in that cycle, the torpedo is consumed, and tack_o pulses in the following cycle.
- R9: A word that is not interruptible, or whose pred_ok_i is 0, is not killed by a held torpedo. It retires through exec_done_i.
- R10: Only one torpedo is held at a time. torp_ready_o stays 0 from acceptance until the kill that consumes it.
- R11: A kill reopens the hatch, so words held behind a tail proceed without any change of olc_zero_i.
- R12: in_ready_o drops to 0 once EF_DEPTH words wait behind a closed hatch.
- R13: While a word is on deck and neither retired nor killed, od_valid_o stays 1 and od_instr_o stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Instruction offered |
| in_instr_i | input | IW | Instruction word; bit IW-1 tail, IW-2 one-shot, IW-3 interruptible |
| in_ready_o | output | 1 | Epilogue queue has room |
| torp_valid_i | input | 1 | Torpedo token offered |
| torp_ready_o | output | 1 | Torpedo slot empty |
| od_valid_o | output | 1 | A word on deck awaits execution |
| od_instr_o | output | IW | On-deck word |
| pred_ok_i | input | 1 | Execute logic: on-deck predicate holds |
| exec_done_i | input | 1 | Execute logic: on-deck word retired |
| od_kill_o | output | 1 | On-deck word killed by torpedo; execute logic must skip it and zero its outer count |
| olc_zero_i | input | 1 | Outer loop counter is zero |
| tack_o | output | 1 | Torpedo acknowledgment token pulse |

## Verification
Each result has a fixed latency. An accepted word appears on deck after the second edge that follows its acceptance. od_kill_o is visible in the same cycle as the on-deck word when a torpedo is already parked, and tack_o follows on the next edge. A recirculated copy returns to the deck within a few cycles after retirement. The bench drives inputs and samples outputs on the falling edge, so each check reads the value registered at the preceding rising edge. Exact edge counts are checked where the requirement fixes them (R2, R8). Observation windows of bounded length are used where only presence or absence matters (R3, R6, R7).

// File: rtl/pump_pkg.sv
package pump_pkg;
    localparam int DEF_IW       = 26;
    localparam int DEF_EF_DEPTH = 4;
    localparam int DEF_IF_DEPTH = 8;

    // flag positions counted down from the word's MSB
    localparam int TAIL_FROM_TOP = 1;
    localparam int ONCE_FROM_TOP = 2;
    localparam int INTR_FROM_TOP = 3;

    typedef enum logic {
        HATCH_OPEN   = 1'b0,
        HATCH_SEALED = 1'b1
    } hatch_e;
endpackage

// File: rtl/pump_fifo.sv
module pump_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.mem[st_q.wr] = push_data_i;
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + AW'(1);
        end
        if (pop_i) begin
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + AW'(1);
        end
        st_d.cnt = st_q.cnt + CW'(push_i) - CW'(pop_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rd];
    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == CW'(DEPTH));
endmodule

// File: rtl/pump_hatch.sv
module pump_hatch
    import pump_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seal_i,
    input  logic unseal_i,
    output logic sealed_o
);
    hatch_e hatch_d, hatch_q;

    always_comb begin
        hatch_d = hatch_q;
        // a zeroing event wins over a tail passing in the same cycle
        if (unseal_i)    hatch_d = HATCH_OPEN;
        else if (seal_i) hatch_d = HATCH_SEALED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hatch_q <= HATCH_OPEN;
        else        hatch_q <= hatch_d;
    end

    assign sealed_o = (hatch_q == HATCH_SEALED);
endmodule

// File: rtl/instr_pump.sv
module instr_pump
    import pump_pkg::*;
#(
    parameter int IW       = DEF_IW,
    parameter int EF_DEPTH = DEF_EF_DEPTH,
    parameter int IF_DEPTH = DEF_IF_DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid_i,
    input  logic [IW-1:0] in_instr_i,
    output logic          in_ready_o,
    input  logic          torp_valid_i,
    output logic          torp_ready_o,
    output logic          od_valid_o,
    output logic [IW-1:0] od_instr_o,
    input  logic          pred_ok_i,
    input  logic          exec_done_i,
    output logic          od_kill_o,
    input  logic          olc_zero_i,
    output logic          tack_o
);
    localparam int TAIL_BIT = IW - TAIL_FROM_TOP;
    localparam int ONCE_BIT = IW - ONCE_FROM_TOP;
    localparam int INTR_BIT = IW - INTR_FROM_TOP;

    typedef struct packed {
        logic [IW-1:0] od_instr;
        logic          exec_pend;
        logic          recirc_pend;
        logic          torp_held;
        logic          tack;
        logic          olc_zero_seen;
    } pump_t;

    pump_t st_d, st_q;

    logic [IW-1:0] ef_head, if_head, if_push_data;
    logic ef_empty, ef_full, if_empty, if_full, sealed;
    logic ef_push, ef_go, tail_pass, ef_to_if;
    logic if_push, od_load, kill, olc_rise, recirc_push, recirc_drop;

    pump_fifo #(.W(IW), .DEPTH(EF_DEPTH)) i_epilogue (
        .clk(clk), .rst_n(rst_n),
        .push_i(ef_push), .push_data_i(in_instr_i), .pop_i(ef_go),
        .head_o(ef_head), .empty_o(ef_empty), .full_o(ef_full)
    );

    pump_fifo #(.W(IW), .DEPTH(IF_DEPTH)) i_ring (
        .clk(clk), .rst_n(rst_n),
        .push_i(if_push), .push_data_i(if_push_data), .pop_i(od_load),
        .head_o(if_head), .empty_o(if_empty), .full_o(if_full)
    );

    pump_hatch i_hatch (
        .clk(clk), .rst_n(rst_n),
        .seal_i(tail_pass), .unseal_i(olc_rise | kill), .sealed_o(sealed)
    );

    always_comb begin
        ef_push   = in_valid_i && !ef_full;
        ef_go     = !ef_empty && !sealed && (ef_head[TAIL_BIT] || !if_full);
        tail_pass = ef_go && ef_head[TAIL_BIT];
        ef_to_if  = ef_go && !ef_head[TAIL_BIT];

        kill = st_q.exec_pend && st_q.torp_held && st_q.od_instr[INTR_BIT] && pred_ok_i;
        olc_rise = olc_zero_i && !st_q.olc_zero_seen;

        recirc_drop = st_q.recirc_pend &&
                      (kill || olc_zero_i || st_q.od_instr[ONCE_BIT]);
        recirc_push = st_q.recirc_pend && !recirc_drop && sealed && !if_full;

        // recirc_push needs a sealed hatch, ef_to_if an open one: never both
        if_push      = recirc_push || ef_to_if;
        if_push_data = recirc_push ? st_q.od_instr : ef_head;

        od_load = !st_q.exec_pend && !st_q.recirc_pend && !if_empty;

        st_d = st_q;
        st_d.exec_pend   = (st_q.exec_pend && !(kill || exec_done_i)) || od_load;
        st_d.recirc_pend = (st_q.recirc_pend && !(recirc_push || recirc_drop)) || od_load;
        if (od_load) st_d.od_instr = if_head;
        if (kill)
            st_d.torp_held = 1'b0;
        else if (torp_valid_i)
            st_d.torp_held = 1'b1;
        st_d.tack          = kill;
        st_d.olc_zero_seen = olc_zero_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            st_q.olc_zero_seen <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready_o   = !ef_full;
    assign torp_ready_o = !st_q.torp_held;
    assign od_valid_o   = st_q.exec_pend;
    assign od_instr_o   = st_q.od_instr;
    assign od_kill_o    = kill;
    assign tack_o       = st_q.tack;
endmodule

// File: rtl/instr_pump_chk.sv
module instr_pump_chk #(
    parameter int IW = 26
) (
    input logic          clk,
    input logic          rst_n,
    input logic          torp_valid_i,
    input logic          torp_ready_o,
    input logic          od_valid_o,
    input logic [IW-1:0] od_instr_o,
    input logic          exec_done_i,
    input logic          od_kill_o,
    input logic          tack_o
);
    // R8
    kill_then_tack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        od_kill_o |=> tack_o);

    // R8
    kill_on_deck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        od_kill_o |-> od_valid_o);

    // R10
    single_torp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (torp_valid_i && torp_ready_o) |=> !torp_ready_o);

    // R13
    deck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (od_valid_o && !exec_done_i && !od_kill_o) |=> (od_valid_o && $stable(od_instr_o)));

    // R3
    no_tail_on_deck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        od_valid_o |-> !od_instr_o[IW-1]);

    // R5
    retire_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (od_valid_o && exec_done_i) |=> !od_valid_o);
endmodule

bind instr_pump instr_pump_chk #(.IW(IW)) i_instr_pump_chk (
    .clk(clk), .rst_n(rst_n), .torp_valid_i(torp_valid_i), .torp_ready_o(torp_ready_o),
    .od_valid_o(od_valid_o), .od_instr_o(od_instr_o), .exec_done_i(exec_done_i),
    .od_kill_o(od_kill_o), .tack_o(tack_o)
);

// File: tb/test_instr_pump.sv
module test_instr_pump;
    localparam int IW = 26;
    localparam int EFD = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid_i = 1'b0, torp_valid_i = 1'b0, pred_ok_i = 1'b1;
    logic exec_done_i = 1'b0, olc_zero_i = 1'b1;
    logic [IW-1:0] in_instr_i = '0;
    logic in_ready_o, torp_ready_o, od_valid_o, od_kill_o, tack_o;
    logic [IW-1:0] od_instr_o;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    instr_pump #(.IW(IW), .EF_DEPTH(EFD), .IF_DEPTH(8)) i_instr_pump (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_instr_i(in_instr_i),
        .in_ready_o(in_ready_o), .torp_valid_i(torp_valid_i), .torp_ready_o(torp_ready_o),
        .od_valid_o(od_valid_o), .od_instr_o(od_instr_o), .pred_ok_i(pred_ok_i),
        .exec_done_i(exec_done_i), .od_kill_o(od_kill_o), .olc_zero_i(olc_zero_i),
        .tack_o(tack_o)
    );

    // row bits: once, intr, olcz, torp, pred | expected kill, expected return
    localparam logic [6:0] ROWS [8] = '{
        7'b0000101, 7'b1000100, 7'b0010100, 7'b0101110,
        7'b0101001, 7'b0001101, 7'b1111110, 7'b0100101
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [IW-1:0] mk(bit tail, bit once, bit intr, int id);
        return {tail, once, intr, (IW-3)'(id)};
    endfunction

    task automatic push(input logic [IW-1:0] w);
        in_valid_i = 1'b1;
        in_instr_i = w;
        for (int i = 0; i < 50 && !in_ready_o; i++) tick();
        tick();
        in_valid_i = 1'b0;
    endtask

    task automatic send_torp();
        torp_valid_i = 1'b1;
        for (int i = 0; i < 50 && !torp_ready_o; i++) tick();
        tick();
        torp_valid_i = 1'b0;
    endtask

    task automatic wait_deck(input int max, output bit found);
        found = 1'b0;
        for (int i = 0; i < max && !found; i++) begin
            if (od_valid_o) found = 1'b1;
            else tick();
        end
    endtask

    task automatic retire();
        exec_done_i = 1'b1;
        tick();
        exec_done_i = 1'b0;
    endtask

    task automatic drain(input int cycles, output int seen);
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            if (od_valid_o) begin
                seen++;
                retire();
            end else tick();
        end
    endtask

    task automatic reopen();
        olc_zero_i = 1'b0;
        tick();
        olc_zero_i = 1'b1;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit found;
        int seen;
        logic [IW-1:0] x, y;

        tick();
        // R1 reset state
        chk(in_ready_o == 1'b1, "R1 in_ready", in_ready_o, 1);
        chk(torp_ready_o == 1'b1, "R1 torp_ready", torp_ready_o, 1);
        chk(od_valid_o == 1'b0, "R1 od_valid", od_valid_o, 0);
        chk(tack_o == 1'b0 && od_kill_o == 1'b0, "R1 tack/kill", tack_o, 0);
        tick();
        rst_n = 1'b1;
        tick();

        // R2 latency through an open hatch (also shows R1 hatch open)
        in_valid_i = 1'b1;
        in_instr_i = mk(0, 1, 0, 11);
        tick();
        in_valid_i = 1'b0;
        tick();
        chk(od_valid_o == 1'b0, "R2 early", od_valid_o, 0);
        tick();
        chk(od_valid_o == 1'b1, "R2 latency", od_valid_o, 1);
        chk(od_instr_o == mk(0, 1, 0, 11), "R2 word", int'(od_instr_o[15:0]), 11);
        retire();

        // R2 ordering, R5/R13 holding without retirement
        push(mk(0, 1, 0, 21));
        push(mk(0, 1, 0, 22));
        push(mk(0, 1, 0, 23));
        for (int k = 21; k <= 23; k++) begin
            wait_deck(20, found);
            chk(found && od_instr_o[15:0] == 16'(k), "R2 order", int'(od_instr_o[15:0]), k);
            if (k == 21) begin
                repeat (5) tick();
                chk(od_valid_o && od_instr_o[15:0] == 16'(21), "R5 hold", int'(od_instr_o[15:0]), 21);
            end
            retire();
            chk(od_valid_o == 1'b0, "R5 gap", od_valid_o, 0);
        end

        // R3 tail closes hatch, R4 zero transition reopens
        push(mk(1, 0, 0, 0));
        push(mk(0, 1, 0, 31));
        repeat (10) tick();
        chk(od_valid_o == 1'b0, "R3 held behind tail", od_valid_o, 0);
        reopen();
        wait_deck(10, found);
        chk(found && od_instr_o[15:0] == 16'd31, "R4 released", int'(od_instr_o[15:0]), 31);
        retire();

        // R12 back-pressure with a closed hatch
        push(mk(1, 0, 0, 0));
        repeat (3) tick();
        seen = 0;
        for (int i = 0; i < EFD + 3; i++) begin
            in_valid_i = 1'b1;
            in_instr_i = mk(0, 1, 0, 40 + i);
            if (in_ready_o) seen++;
            tick();
        end
        in_valid_i = 1'b0;
        chk(seen == EFD, "R12 accepted", seen, EFD);
        chk(in_ready_o == 1'b0, "R12 in_ready", in_ready_o, 0);
        reopen();
        drain(60, seen);
        chk(seen == EFD, "R4 drained", seen, EFD);

        // R11 kill reopens hatch, R10 single torpedo, R9 predicate gating
        x = mk(0, 1, 1, 51);
        y = mk(0, 1, 0, 52);
        olc_zero_i = 1'b0;
        pred_ok_i = 1'b0;
        push(x);
        push(mk(1, 0, 0, 0));
        push(y);
        wait_deck(10, found);
        chk(found && od_instr_o == x, "R11 setup", int'(od_instr_o[15:0]), 51);
        torp_valid_i = 1'b1;
        tick();
        repeat (3) begin
            tick();
            chk(torp_ready_o == 1'b0, "R10 slot busy", torp_ready_o, 0);
        end
        torp_valid_i = 1'b0;
        chk(od_kill_o == 1'b0 && od_instr_o == x, "R9 predicate false", od_kill_o, 0);
        pred_ok_i = 1'b1;
        #0.1;
        chk(od_kill_o == 1'b1, "R8 kill", od_kill_o, 1);
        tick();
        chk(tack_o == 1'b1, "R8 tack", tack_o, 1);
        chk(torp_ready_o == 1'b1, "R8 slot freed", torp_ready_o, 1);
        wait_deck(10, found);
        chk(found && od_instr_o == y, "R11 reopened", int'(od_instr_o[15:0]), 52);
        retire();
        olc_zero_i = 1'b1;
        tick();

        // table of scenarios: R6 R7 R8 R9
        foreach (ROWS[r]) begin
            x = mk(0, ROWS[r][6], ROWS[r][5], 100 + r);
            pred_ok_i = ROWS[r][2];
            olc_zero_i = ROWS[r][4];
            if (ROWS[r][3]) send_torp();
            push(x);
            push(mk(1, 0, 0, 0));
            wait_deck(20, found);
            chk(found && od_instr_o == x, "R2 row deck", int'(od_instr_o[15:0]), 100 + r);
            chk(od_kill_o == ROWS[r][1], "R8/R9 row kill", od_kill_o, ROWS[r][1]);
            if (ROWS[r][1]) begin
                tick();
                chk(tack_o == 1'b1, "R8 row tack", tack_o, 1);
                olc_zero_i = 1'b1;
            end else begin
                retire();
            end
            found = 1'b0;
            for (int i = 0; i < 8; i++) begin
                if (od_valid_o && od_instr_o == x) found = 1'b1;
                tick();
            end
            chk(found == ROWS[r][0], "R6/R7 row return", found, ROWS[r][0]);
            reopen();
            drain(40, seen);
            chk(od_valid_o == 1'b0, "R7 row drained", od_valid_o, 0);
            if (!torp_ready_o) begin
                chk(torp_ready_o == 1'b0, "R10 held torpedo", torp_ready_o, 0);
                pred_ok_i = 1'b1;
                push(mk(0, 1, 1, 99));
                wait_deck(10, found);
                chk(found && od_kill_o == 1'b1, "R8 cleanup kill", od_kill_o, 1);
                tick();
                chk(tack_o == 1'b1, "R8 cleanup tack", tack_o, 1);
                drain(10, seen);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule